// File: doc/BRIEF.md
# Paged Address Translator with Translation Cache

This block turns a logical address into a physical one using fixed-size pages. The upper bits of the logical address form a virtual page number and the lower `PAGE_BITS` bits form the offset, which passes through untouched. A small fully associative translation cache (TLB) is compared against the page number in a single cycle. When the cache hits, the translation is returned without touching memory.

When the cache misses, the block checks the page number against a table-length input. A page number that is out of range faults at once. Otherwise the block fetches one page-table entry through a synchronous read port, at the table base plus the page number. It then either builds the physical address from the entry's frame number or reports a fault when the entry's valid bit is clear. Valid entries fetched this way are installed in the cache in round-robin order.

A flush input empties the cache. Two running counters record hit and miss responses so the hit ratio can be observed. One request is in flight at a time, and `req_ready` is low during a table fetch.

Top module: `page_xlate`

## Requirements
- R1: After a synchronous active-high reset, `resp_valid` and `mem_rd_en` are 0, `req_ready` is 1, both counters read 0, and the cache holds no entries.
- R2: A successful translation returns `resp_paddr` = {frame, offset}, where the offset is the logical address's low `PAGE_BITS` bits, unchanged.
- R3: A request accepted while its page is cached gives `resp_valid` with `resp_hit`=1 in the cycle after acceptance, and no memory read is issued.
- R4: On a cache miss with an in-range page, `mem_rd_en` is high for exactly one cycle, in the cycle after acceptance, with `mem_rd_addr` = `pt_base` + page number. The entry is taken from `mem_rd_data` in the following cycle. The response is valid three cycles after acceptance, and `req_ready` stays low until the response cycle.
- R5: A missing page number greater than or equal to `pt_len` gives a fault response in the cycle after acceptance, with no memory read.
- R6: A page-table entry holds the valid flag at bit `FRAME_W` and the frame number in bits `FRAME_W-1:0`. An entry with the flag clear gives a fault response and is not cached, so a repeated access to that page fetches the entry again.
- R7: Each valid fetched entry is written into the cache. Slots are filled and replaced in round-robin order starting at slot 0. With `TLB_ENTRIES` slots full, the next refill evicts the oldest installed page. A cache hit does not change the order.
- R8: A cycle with `flush` high empties the cache and returns the replacement order to slot 0. A lookup in the same cycle misses, and a refill in the same cycle is dropped.
- R9: `hit_count` increments with every response that has `resp_hit`=1. `miss_count` increments with every other response, faults included. Both counters change in the response cycle.
- R10: A fault response has `resp_fault`=1, `resp_hit`=0 and `resp_paddr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the translation cache |
| req_valid | input | 1 | Translation request |
| req_laddr | input | LA_W | Logical address |
| req_ready | output | 1 | Request accepted when high with req_valid |
| pt_base | input | PT_AW | Page-table base address (entry units) |
| pt_len | input | LA_W-PAGE_BITS+1 | Number of page-table entries |
| mem_rd_en | output | 1 | Page-table read strobe |
| mem_rd_addr | output | PT_AW | Page-table read address |
| mem_rd_data | input | FRAME_W+1 | Entry returned one cycle after the strobe |
| resp_valid | output | 1 | Response strobe |
| resp_paddr | output | FRAME_W+PAGE_BITS | Physical address |
| resp_hit | output | 1 | Translation came from the cache |
| resp_fault | output | 1 | Length or valid-flag fault |
| hit_count | output | CNT_W | Hit responses since reset |
| miss_count | output | CNT_W | Non-hit responses since reset |

## Verification
The bench builds the block with 512-byte pages, 16-bit logical addresses, 8-bit frames and only four cache slots. With four slots, a fifth distinct page forces an eviction within a handful of requests, so the round-robin order and its reset by a flush can be observed directly. A table length of 20 entries, with one entry marked invalid and page numbers drawn up to 23, keeps length faults, valid-flag faults, hits and table fetches all frequent in the random phase. Concurrent flush-and-request cycles are issued both in the directed sequence and at random.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // walk controller states
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WAIT = 2'd2
  } walk_st_t;
endpackage

// File: rtl/xlat_ctr.sv
module xlat_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int VPN_W   = 20,
  parameter int FRAME_W = 20,
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  input  logic               wr_en,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [FRAME_W-1:0] wr_frame
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] match;
  logic [VPN_W-1:0]   tag [ENTRIES];
  logic [FRAME_W-1:0] frm [ENTRIES];
  logic [IDX_W-1:0]   ptr;

  // parallel compare of every slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld[g] && (tag[g] == lk_vpn);
  end

  always_comb begin
    lk_frame = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) lk_frame = lk_frame | frm[i];
  end

  assign lk_hit = (|match) && !flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      ptr <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag[i] <= '0;
        frm[i] <= '0;
      end
    end else if (flush) begin
      vld <= '0;
      ptr <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ptr == IDX_W'(i)) begin
          vld[i] <= 1'b1;
          tag[i] <= wr_vpn;
          frm[i] <= wr_frame;
        end
      end
      ptr <= (ptr == IDX_W'(ENTRIES-1)) ? '0 : ptr + IDX_W'(1);
    end
  end

  AST_TLB_NO_DUP: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match)); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> ($countones(vld) == 0)); // R8
endmodule

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int LA_W        = 32,
  parameter int PAGE_BITS   = 12,
  parameter int FRAME_W     = 20,
  parameter int PT_AW       = 32,
  parameter int TLB_ENTRIES = 8,
  parameter int CNT_W       = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           flush,
  input  logic                           req_valid,
  input  logic [LA_W-1:0]                req_laddr,
  output logic                           req_ready,
  input  logic [PT_AW-1:0]               pt_base,
  input  logic [LA_W-PAGE_BITS:0]        pt_len,
  output logic                           mem_rd_en,
  output logic [PT_AW-1:0]               mem_rd_addr,
  input  logic [FRAME_W:0]               mem_rd_data,
  output logic                           resp_valid,
  output logic [FRAME_W+PAGE_BITS-1:0]   resp_paddr,
  output logic                           resp_hit,
  output logic                           resp_fault,
  output logic [CNT_W-1:0]               hit_count,
  output logic [CNT_W-1:0]               miss_count
);
  import xlat_pkg::*;

  localparam int VPN_W = LA_W - PAGE_BITS;
  localparam int PA_W  = FRAME_W + PAGE_BITS;

  walk_st_t               st;
  logic [VPN_W-1:0]       vpn, sv_vpn;
  logic [PAGE_BITS-1:0]   off, sv_off;
  logic                   accept, len_bad, lk_hit, pte_ok, refill;
  logic                   inc_hit, inc_miss;
  logic [FRAME_W-1:0]     lk_frame;

  assign vpn       = req_laddr[LA_W-1:PAGE_BITS];
  assign off       = req_laddr[PAGE_BITS-1:0];
  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign len_bad   = ({1'b0, vpn} >= pt_len);
  assign pte_ok    = mem_rd_data[FRAME_W];
  assign refill    = (st == ST_WAIT) && pte_ok;
  assign inc_hit   = accept && lk_hit;
  assign inc_miss  = (accept && !lk_hit && len_bad) || (st == ST_WAIT);

  xlat_tlb #(.VPN_W(VPN_W), .FRAME_W(FRAME_W), .ENTRIES(TLB_ENTRIES)) u_tlb (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .lk_vpn   (vpn),
    .lk_hit   (lk_hit),
    .lk_frame (lk_frame),
    .wr_en    (refill),
    .wr_vpn   (sv_vpn),
    .wr_frame (mem_rd_data[FRAME_W-1:0])
  );

  xlat_ctr #(.CNT_W(CNT_W)) u_hits (
    .clk(clk), .rst(rst), .inc(inc_hit), .count(hit_count));
  xlat_ctr #(.CNT_W(CNT_W)) u_miss (
    .clk(clk), .rst(rst), .inc(inc_miss), .count(miss_count));

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      resp_valid  <= 1'b0;
      resp_paddr  <= '0;
      resp_hit    <= 1'b0;
      resp_fault  <= 1'b0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      sv_vpn      <= '0;
      sv_off      <= '0;
    end else begin
      resp_valid <= 1'b0;
      mem_rd_en  <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            if (lk_hit) begin
              resp_valid <= 1'b1;
              resp_hit   <= 1'b1;
              resp_fault <= 1'b0;
              resp_paddr <= {lk_frame, off};
            end else if (len_bad) begin
              resp_valid <= 1'b1;
              resp_hit   <= 1'b0;
              resp_fault <= 1'b1;
              resp_paddr <= '0;
            end else begin
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= pt_base + PT_AW'(vpn);
              sv_vpn      <= vpn;
              sv_off      <= off;
              st          <= ST_RD;
            end
          end
        end
        ST_RD: st <= ST_WAIT;
        ST_WAIT: begin
          resp_valid <= 1'b1;
          resp_hit   <= 1'b0;
          resp_fault <= !pte_ok;
          resp_paddr <= pte_ok ? {mem_rd_data[FRAME_W-1:0], sv_off} : PA_W'(0);
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_HIT_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (accept && lk_hit) |=> (resp_valid && resp_hit && !mem_rd_en)); // R3
  AST_READ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> (!mem_rd_en && !req_ready)); // R4
  AST_LEN_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (accept && !lk_hit && len_bad) |=> (!mem_rd_en && resp_valid && resp_fault)); // R5
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault) |-> (resp_paddr == '0 && !resp_hit)); // R10
  AST_HIT_COUNT: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_hit) |-> (hit_count == $past(hit_count) + CNT_W'(1))); // R9
endmodule

// File: tb/tb_page_xlate.sv
module tb_page_xlate;
  localparam int LA_W = 16, PB = 9, FW = 8, PAW = 10, NE = 4, CW = 16;

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0, req_valid = 1'b0;
  logic [LA_W-1:0] req_laddr = '0;
  logic req_ready, mem_rd_en, resp_valid, resp_hit, resp_fault;
  logic [PAW-1:0] pt_base = 10'd100;
  logic [7:0] pt_len = 8'd20;
  logic [PAW-1:0] mem_rd_addr;
  logic [FW:0] mem_rd_data = '0;
  logic [16:0] resp_paddr;
  logic [CW-1:0] hit_count, miss_count;

  int n_chk = 0, n_err = 0, cyc = 0;
  logic [FW:0] pt [1024];

  always #2 clk = ~clk;

  page_xlate #(.LA_W(LA_W), .PAGE_BITS(PB), .FRAME_W(FW), .PT_AW(PAW),
               .TLB_ENTRIES(NE), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid),
    .req_laddr(req_laddr), .req_ready(req_ready), .pt_base(pt_base),
    .pt_len(pt_len), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .resp_valid(resp_valid),
    .resp_paddr(resp_paddr), .resp_hit(resp_hit), .resp_fault(resp_fault),
    .hit_count(hit_count), .miss_count(miss_count));

  function automatic logic [7:0] fr(int v);
    return 8'(8'h40 + v * 3);
  endfunction

  // synchronous page-table memory
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= pt[mem_rd_addr];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference: FIFO queue of cached pages
  int q_v[$], q_f[$];
  int ms = 0, m_vpn = 0, m_off = 0, m_addr = 0, m_hits = 0, m_miss = 0;
  logic m_rv = 0, m_rd = 0, m_hit = 0, m_flt = 0;
  logic [16:0] m_pa = '0;

  always @(posedge clk) begin
    if (rst) begin
      ms = 0; m_rv = 0; m_rd = 0; m_hits = 0; m_miss = 0;
      q_v.delete(); q_f.delete();
    end else begin
      m_rv = 0; m_rd = 0;
      if (ms == 0) begin
        if (req_valid) begin
          int v, o, hi;
          v = int'(req_laddr[15:9]); o = int'(req_laddr[8:0]); hi = -1;
          if (!flush) foreach (q_v[i]) if (q_v[i] == v) hi = i;
          if (hi >= 0) begin
            m_rv = 1; m_hit = 1; m_flt = 0;
            m_pa = {8'(q_f[hi]), 9'(o)}; m_hits++;
          end else if (v >= int'(pt_len)) begin
            m_rv = 1; m_hit = 0; m_flt = 1; m_pa = '0; m_miss++;
          end else begin
            m_rd = 1; m_addr = int'(pt_base) + v; m_vpn = v; m_off = o; ms = 1;
          end
        end
        if (flush) begin q_v.delete(); q_f.delete(); end
      end else if (ms == 1) begin
        if (flush) begin q_v.delete(); q_f.delete(); end
        ms = 2;
      end else begin
        logic [FW:0] e;
        e = pt[m_addr];
        m_rv = 1; m_hit = 0; m_miss++; ms = 0;
        if (e[FW]) begin
          m_flt = 0; m_pa = {e[7:0], 9'(m_off)};
        end else begin
          m_flt = 1; m_pa = '0;
        end
        if (flush) begin q_v.delete(); q_f.delete(); end
        else if (e[FW]) begin
          if (q_v.size() == NE) begin void'(q_v.pop_front()); void'(q_f.pop_front()); end
          q_v.push_back(m_vpn); q_f.push_back(int'(e[7:0]));
        end
      end
    end
  end

  // compare against the reference on every clock
  always @(negedge clk) if (!rst) begin
    chk("R4 req_ready", 32'(req_ready), 32'(ms == 0));
    chk("R4 mem_rd_en", 32'(mem_rd_en), 32'(m_rd));
    if (m_rd) chk("R4 mem_rd_addr", 32'(mem_rd_addr), 32'(m_addr));
    chk("R3 resp_valid", 32'(resp_valid), 32'(m_rv));
    if (m_rv) begin
      chk("R7 resp_hit", 32'(resp_hit), 32'(m_hit));
      chk("R5 resp_fault", 32'(resp_fault), 32'(m_flt));
      chk("R2 resp_paddr", 32'(resp_paddr), 32'(m_pa));
    end
    chk("R9 hit_count", 32'(hit_count), 32'(m_hits));
    chk("R9 miss_count", 32'(miss_count), 32'(m_miss));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  int t_hits = 0, t_miss = 0;

  task automatic xlate(input int v, input int o, input logic with_flush,
                       output logic h, output logic f,
                       output logic [16:0] pa, output int lat);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; flush = with_flush;
    req_laddr = {7'(v), 9'(o)};
    @(negedge clk);
    req_valid = 1'b0; flush = 1'b0;
    lat = 0;
    while (!resp_valid && lat < 20) begin @(negedge clk); lat++; end
    h = resp_hit; f = resp_fault; pa = resp_paddr;
    if (h) t_hits++; else t_miss++;
  endtask

  initial begin
    logic h, f;
    logic [16:0] pa;
    int lat;
    for (int i = 0; i < 1024; i++) pt[i] = '0;
    for (int v = 0; v < 20; v++) pt[100 + v] = {(v != 7), fr(v)};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 resp_valid", 32'(resp_valid), 0);
    chk("R1 mem_rd_en", 32'(mem_rd_en), 0);
    chk("R1 req_ready", 32'(req_ready), 1);
    chk("R1 hit_count", 32'(hit_count), 0);
    chk("R1 miss_count", 32'(miss_count), 0);

    // R4 / R2 first access walks the table
    xlate(3, 9'h1AB, 1'b0, h, f, pa, lat);
    chk("R1 empty cache", 32'(h), 0);
    chk("R4 miss latency", 32'(lat), 2);
    chk("R2 paddr miss", 32'(pa), 32'({fr(3), 9'h1AB}));
    // R3 second access hits
    xlate(3, 5, 1'b0, h, f, pa, lat);
    chk("R3 hit flag", 32'(h), 1);
    chk("R3 hit latency", 32'(lat), 0);
    chk("R2 paddr hit", 32'(pa), 32'({fr(3), 9'd5}));
    // R5 length fault, R10 zero address
    xlate(25, 7, 1'b0, h, f, pa, lat);
    chk("R5 fault", 32'(f), 1);
    chk("R5 latency", 32'(lat), 0);
    chk("R10 fault paddr", 32'(pa), 0);
    // R6 invalid entry faults and is never cached
    xlate(7, 1, 1'b0, h, f, pa, lat);
    chk("R6 fault", 32'(f), 1);
    chk("R6 latency", 32'(lat), 2);
    xlate(7, 1, 1'b0, h, f, pa, lat);
    chk("R6 refetch latency", 32'(lat), 2);
    chk("R6 refetch hit", 32'(h), 0);
    // R7 round-robin eviction
    xlate(0, 0, 1'b0, h, f, pa, lat);
    xlate(1, 0, 1'b0, h, f, pa, lat);
    xlate(2, 0, 1'b0, h, f, pa, lat);
    xlate(4, 0, 1'b0, h, f, pa, lat);
    chk("R7 fill miss", 32'(h), 0);
    xlate(0, 9, 1'b0, h, f, pa, lat);
    chk("R7 survivor hit", 32'(h), 1);
    xlate(3, 9, 1'b0, h, f, pa, lat);
    chk("R7 evicted miss", 32'(h), 0);
    chk("R7 evicted latency", 32'(lat), 2);
    // R8 flush alone
    flush = 1'b1; @(negedge clk); flush = 1'b0;
    xlate(1, 2, 1'b0, h, f, pa, lat);
    chk("R8 after flush", 32'(h), 0);
    // R8 flush concurrent with lookup
    xlate(1, 2, 1'b1, h, f, pa, lat);
    chk("R8 concurrent flush", 32'(h), 0);
    xlate(1, 2, 1'b0, h, f, pa, lat);
    chk("R8 refilled hit", 32'(h), 1);
    // R9 counters against tally
    chk("R9 hit tally", 32'(hit_count), 32'(t_hits));
    chk("R9 miss tally", 32'(miss_count), 32'(t_miss));
    chk("R9 hit total", 32'(hit_count), 3);
    chk("R9 miss total", 32'(miss_count), 11);

    // random traffic compared cycle by cycle
    for (int k = 0; k < 600; k++) begin
      req_valid = ($urandom_range(0, 9) < 7);
      req_laddr = {7'($urandom_range(0, 23)), 9'($urandom_range(0, 511))};
      flush = ($urandom_range(0, 29) == 0);
      @(negedge clk);
    end
    req_valid = 1'b0; flush = 1'b0;
    repeat (5) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule